// File: doc/BRIEF.md
# Option-Locked Watchdog Timer

This block is a watchdog timer whose operating mode is decided once, at reset, by a strap bit that stands in for a non-volatile option setting. In the locked mode the counter always runs from the low-speed internal clock. That clock cannot be stopped, and no software write can disable the watchdog. In the flexible mode software chooses the count source: the system clock, the low-speed clock, or no clock at all. Choosing no clock parks the watchdog.

Both modes come out of reset with the longest interval and the low-speed source. Software gets exactly one configuration write. Any further write is refused and raises a sticky access error, which holds the reset request high. Software keeps the watchdog quiet by pulsing the clear input before the selected number of count ticks has passed. If it does not, the block raises its reset request for one system-clock cycle.

The low-speed clock arrives as an asynchronous level. A synchroniser turns each of its rising edges into a single count tick in the system clock domain. When the system clock is the source, counting pauses during HALT/STOP and while the oscillator is still stabilising. When the low-speed clock is the source, counting pauses in HALT/STOP only if software has switched that oscillator off, and only in the flexible mode.

Top module: `wdt_optlock`

## Requirements
- R1: After reset release `wdt_reset` and `acc_err` are low, the source is the low-speed clock and the interval is the longest, 2^(MIN_LOG2+2^SEL_W-1) ticks (2^18 with defaults).
- R2: With interval field value s, `wdt_reset` rises exactly 2^(MIN_LOG2+s) count ticks after the last clear (2^11..2^18 for s=0..7 with defaults), stays high one cycle, and counting restarts from zero.
- R3: A `kick` pulse sets the count to zero, so the full interval restarts from that pulse.
- R4: With `opt_locked` high at reset, the source stays the low-speed clock whatever the source field of a write holds; the interval field is still taken once.
- R5: In the flexible mode the source field `cfg_wdata[SEL_W+1:SEL_W]` selects 2'b00 = stopped, 2'b01 = low-speed, 2'b10 = system clock, 2'b11 = low-speed; when stopped, no reset request is ever raised.
- R6: Only the first configuration write after reset is taken. Every later write leaves the settings unchanged and sets `acc_err`, which stays high until reset and holds `wdt_reset` high.
- R7: With the system clock as source, one tick is counted per system-clock cycle, but none while `sleep` is high or `sys_osc_stable` is low.
- R8: With the low-speed source, ticks pause while `sleep` and `ls_osc_off` are both high, but only in the flexible mode; in the locked mode `ls_osc_off` has no effect.
- R9: Each rising edge of the asynchronous `ls_clk` input yields exactly one count tick, delayed by the synchroniser.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| opt_locked | input | 1 | Mode strap, captured on the first clock after reset: 1 = locked, 0 = flexible |
| sys_osc_stable | input | 1 | System oscillator has finished stabilising |
| ls_clk | input | 1 | Low-speed internal clock, asynchronous level |
| ls_osc_off | input | 1 | Software has switched the low-speed oscillator off |
| sleep | input | 1 | CPU is in HALT or STOP |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | SEL_W+2 | [SEL_W-1:0] interval field, [SEL_W+1:SEL_W] source field |
| kick | input | 1 | Clear strobe that restarts the interval |
| wdt_reset | output | 1 | Reset request: one-cycle pulse at timeout, held high while an access error is set |
| acc_err | output | 1 | Sticky flag set by a refused configuration write |

## Verification
The assertions check on every cycle the properties that depend only on the current cycle or the one before it. These are: a clear empties the counter, a stopped or paused source leaves the count unchanged, the locked mode never leaves the low-speed source, the access error is sticky and holds the reset request, and a timeout pulse lasts one cycle. The exact length of each interval cannot be checked one cycle at a time, so the bench covers it instead. It resets the block for every value of the interval field in a reduced configuration and counts the cycles to timeout. The bench also exercises pauses in the middle of an interval and the synchronised low-speed tick rate.

// File: rtl/wdt_ol_pkg.sv
package wdt_ol_pkg;

   typedef enum logic [1:0] {
      SRC_STOP = 2'b00,
      SRC_LS   = 2'b01,
      SRC_SYS  = 2'b10
   } src_e;

   // Source field decode; 2'b11 maps to the low-speed clock.
   function automatic src_e decode_src(input logic [1:0] f);
      case (f)
         2'b00:   decode_src = SRC_STOP;
         2'b10:   decode_src = SRC_SYS;
         default: decode_src = SRC_LS;
      endcase
   endfunction

endpackage

// File: rtl/wdt_ol_sync.sv
module wdt_ol_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_o
);
   logic [STAGES-1:0] chain;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("wdt_ol_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[STAGES-1];
   end

   assign rise_o = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/wdt_ol_cfg.sv
module wdt_ol_cfg
   import wdt_ol_pkg::*;
#(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             opt_locked,
   input  logic             cfg_we,
   input  logic [SEL_W-1:0] cfg_sel,
   input  logic [1:0]       cfg_src,
   output logic             locked_o,
   output logic [SEL_W-1:0] sel_o,
   output src_e             src_o,
   output logic             err_o
);
   logic             cap_q;
   logic             locked_q;
   logic             done_q;
   logic [SEL_W-1:0] sel_q;
   src_e             src_q;
   logic             err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q    <= 1'b0;
         locked_q <= 1'b1;
         done_q   <= 1'b0;
         sel_q    <= '1;
         src_q    <= SRC_LS;
         err_q    <= 1'b0;
      end else begin
         if (!cap_q) begin
            cap_q    <= 1'b1;
            locked_q <= opt_locked;
         end
         if (cfg_we && cap_q) begin
            if (!done_q) begin
               done_q <= 1'b1;
               sel_q  <= cfg_sel;
               if (!locked_q) src_q <= decode_src(cfg_src);
            end else begin
               err_q <= 1'b1;
            end
         end
      end
   end

   assign locked_o = locked_q;
   assign sel_o    = sel_q;
   assign src_o    = src_q;
   assign err_o    = err_q;
endmodule

// File: rtl/wdt_ol_gate.sv
module wdt_ol_gate
   import wdt_ol_pkg::*;
(
   input  logic locked,
   input  src_e src,
   input  logic sys_osc_stable,
   input  logic ls_rise,
   input  logic ls_osc_off,
   input  logic sleep,
   output logic tick_o
);
   logic ls_paused;

   always_comb begin
      ls_paused = sleep && ls_osc_off && !locked;
      case (src)
         SRC_SYS: tick_o = sys_osc_stable && !sleep;
         SRC_LS:  tick_o = ls_rise && !ls_paused;
         default: tick_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/wdt_ol_counter.sv
module wdt_ol_counter #(
   parameter int CNT_W = 18,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             kick,
   input  logic [SEL_W-1:0] sel,
   output logic [CNT_W-1:0] cnt_o,
   output logic             tmo_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;
   logic             at_end;
   logic             tmo_q;

   // Terminal value 2^(CNT_W - (2^SEL_W-1) + sel) - 1.
   assign limit  = {CNT_W{1'b1}} >> (~sel);
   assign at_end = (cnt_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tmo_q <= 1'b0;
      end else begin
         tmo_q <= tick && at_end && !kick;
         if (kick)        cnt_q <= '0;
         else if (tick)   cnt_q <= at_end ? '0 : cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;
   assign tmo_o = tmo_q;
endmodule

// File: rtl/wdt_optlock.sv
module wdt_optlock
   import wdt_ol_pkg::*;
#(
   parameter int MIN_LOG2    = 11,
   parameter int SEL_W       = 3,
   parameter int SYNC_STAGES = 2,
   localparam int CNT_W      = MIN_LOG2 + (1 << SEL_W) - 1,
   localparam int WD_W       = SEL_W + 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            opt_locked,
   input  logic            sys_osc_stable,
   input  logic            ls_clk,
   input  logic            ls_osc_off,
   input  logic            sleep,
   input  logic            cfg_we,
   input  logic [WD_W-1:0] cfg_wdata,
   input  logic            kick,
   output logic            wdt_reset,
   output logic            acc_err
);
   generate
      if (MIN_LOG2 < 1) begin : g_bad_min
         $error("wdt_optlock: MIN_LOG2 must be at least 1");
      end
      if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
         $error("wdt_optlock: SEL_W must lie in 1..4");
      end
   endgenerate

   logic             locked;
   logic [SEL_W-1:0] sel;
   src_e             src;
   logic             err;
   logic             ls_rise;
   logic             tick;
   logic [CNT_W-1:0] cnt;
   logic             tmo;

   wdt_ol_cfg #(.SEL_W(SEL_W)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .opt_locked (opt_locked),
      .cfg_we     (cfg_we),
      .cfg_sel    (cfg_wdata[SEL_W-1:0]),
      .cfg_src    (cfg_wdata[SEL_W+1:SEL_W]),
      .locked_o   (locked),
      .sel_o      (sel),
      .src_o      (src),
      .err_o      (err)
   );

   wdt_ol_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (ls_clk),
      .rise_o   (ls_rise)
   );

   wdt_ol_gate u_gate (
      .locked         (locked),
      .src            (src),
      .sys_osc_stable (sys_osc_stable),
      .ls_rise        (ls_rise),
      .ls_osc_off     (ls_osc_off),
      .sleep          (sleep),
      .tick_o         (tick)
   );

   wdt_ol_counter #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .kick  (kick),
      .sel   (sel),
      .cnt_o (cnt),
      .tmo_o (tmo)
   );

   assign wdt_reset = tmo | err;
   assign acc_err   = err;
endmodule

// File: rtl/wdt_optlock_chk.sv
module wdt_optlock_chk
   import wdt_ol_pkg::*;
#(
   parameter int CNT_W = 18
) (
   input logic             clk,
   input logic             rst_n,
   input logic             kick,
   input logic             sleep,
   input logic             sys_osc_stable,
   input logic             wdt_reset,
   input logic             acc_err,
   input logic             locked,
   input src_e             src,
   input logic [CNT_W-1:0] cnt
);
   p_kick_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> (cnt == '0));

   p_tmo_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wdt_reset && !acc_err) |=> (!wdt_reset || acc_err));

   p_locked_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> (src == SRC_LS));

   p_stop_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_STOP && !kick) |=> $stable(cnt));

   p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      acc_err |=> acc_err);

   p_err_holds_rst_r6: assert property (@(posedge clk) disable iff (!rst_n)
      acc_err |-> wdt_reset);

   p_sys_pause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_SYS && (sleep || !sys_osc_stable) && !kick) |=> $stable(cnt));
endmodule

bind wdt_optlock wdt_optlock_chk #(.CNT_W(CNT_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .kick           (kick),
   .sleep          (sleep),
   .sys_osc_stable (sys_osc_stable),
   .wdt_reset      (wdt_reset),
   .acc_err        (acc_err),
   .locked         (locked),
   .src            (src),
   .cnt            (cnt)
);

// File: tb/wdt_optlock_bench.sv
module wdt_optlock_bench;
   localparam int MIN_LOG2 = 3;
   localparam int SEL_W    = 3;
   localparam int MAX_LOG2 = MIN_LOG2 + (1 << SEL_W) - 1;

   logic clk = 1'b0, rst_n = 1'b0, opt_locked = 1'b0, sys_osc_stable = 1'b1;
   logic ls_clk = 1'b0, ls_osc_off = 1'b0, sleep = 1'b0, cfg_we = 1'b0, kick = 1'b0;
   logic [SEL_W+1:0] cfg_wdata = '0;
   logic wdt_reset, acc_err;
   int checks = 0, errors = 0;

   always #4 clk = ~clk;
   initial begin #3; forever #16 ls_clk = ~ls_clk; end

   wdt_optlock #(.MIN_LOG2(MIN_LOG2), .SEL_W(SEL_W)) u_wdt_optlock (
      .clk(clk), .rst_n(rst_n), .opt_locked(opt_locked), .sys_osc_stable(sys_osc_stable),
      .ls_clk(ls_clk), .ls_osc_off(ls_osc_off), .sleep(sleep), .cfg_we(cfg_we),
      .cfg_wdata(cfg_wdata), .kick(kick), .wdt_reset(wdt_reset), .acc_err(acc_err));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic lk);
      @(negedge clk);
      rst_n = 1'b0; opt_locked = lk; sleep = 0; ls_osc_off = 0; sys_osc_stable = 1;
      cfg_we = 0; kick = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic write_cfg(input int sel, input int src);
      cfg_wdata = {2'(src), SEL_W'(sel)};
      cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic do_kick();
      kick = 1'b1;
      @(negedge clk);
      kick = 1'b0;
   endtask

   // Cycles from the clear edge until wdt_reset is seen; limit if never.
   task automatic measure(input int limit, output int n);
      n = 0;
      while (n < limit) begin
         @(negedge clk);
         n++;
         if (wdt_reset) break;
      end
   endtask

   task automatic quiet(input int cycles, output bool_seen);
      bit seen;
      seen = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (wdt_reset) seen = 1;
      end
      bool_seen = seen;
   endtask

   typedef bit bool_seen;

   initial begin
      int n;
      bit seen;

      // R1: reset state and default longest interval on the low-speed clock
      do_reset(1'b0);
      check(wdt_reset == 0, "R1 reset request low", wdt_reset, 0);
      check(acc_err == 0, "R1 error low", acc_err, 0);
      do_kick();
      measure(8 * (1 << MAX_LOG2), n);
      check(n >= 4 * (1 << MAX_LOG2) - 8 && n <= 4 * (1 << MAX_LOG2) + 8,
            "R1 default interval", n, 4 * (1 << MAX_LOG2));

      // R2 + R5: sweep every interval on the system clock source
      for (int s = 0; s < (1 << SEL_W); s++) begin
         do_reset(1'b0);
         write_cfg(s, 2);
         do_kick();
         measure(4 * (1 << MAX_LOG2), n);
         check(n == (1 << (MIN_LOG2 + s)), "R2 interval sweep", n, 1 << (MIN_LOG2 + s));
         @(negedge clk);
         check(wdt_reset == 0, "R2 single-cycle pulse", wdt_reset, 0);
         measure(4 * (1 << MAX_LOG2), n);
         check(n == (1 << (MIN_LOG2 + s)) - 1, "R2 restart after timeout", n,
               (1 << (MIN_LOG2 + s)) - 1);
      end

      // R3: a clear mid-interval restarts the full interval
      do_reset(1'b0);
      write_cfg(1, 2);
      do_kick();
      repeat (10) @(negedge clk);
      do_kick();
      measure(200, n);
      check(n == 16, "R3 clear restarts interval", n, 16);

      // R5: stopped source never times out
      do_reset(1'b0);
      write_cfg(0, 0);
      quiet(3000, seen);
      check(seen == 0, "R5 stopped source silent", seen, 0);

      // R4: locked mode ignores a stop request in the source field
      do_reset(1'b1);
      write_cfg(0, 0);
      do_kick();
      measure(400, n);
      check(n >= 28 && n <= 44, "R4 locked keeps low-speed source", n, 32);

      // R4: locked mode ignores a system-clock request too (rate stays low-speed)
      do_reset(1'b1);
      write_cfg(1, 2);
      do_kick();
      measure(400, n);
      check(n >= 60 && n <= 76, "R4 locked ignores source field", n, 64);

      // R6: a second write is refused, error sticks and holds the reset request
      do_reset(1'b0);
      write_cfg(0, 2);
      check(acc_err == 0, "R6 first write accepted", acc_err, 0);
      write_cfg(7, 0);
      check(acc_err == 1, "R6 second write flags error", acc_err, 1);
      quiet(0, seen);
      repeat (20) @(negedge clk);
      check(acc_err == 1 && wdt_reset == 1, "R6 error sticky, reset held",
            {acc_err, wdt_reset}, 3);

      // R7: system source pauses in sleep and while oscillator not stable
      do_reset(1'b0);
      write_cfg(0, 2);
      do_kick();
      sleep = 1'b1;
      quiet(40, seen);
      check(seen == 0, "R7 paused in sleep", seen, 0);
      sleep = 1'b0;
      sys_osc_stable = 1'b0;
      quiet(40, seen);
      check(seen == 0, "R7 paused while stabilising", seen, 0);
      sys_osc_stable = 1'b1;
      measure(100, n);
      check(n == 8, "R7 resumes with count kept", n, 8);

      // R8: flexible low-speed source pauses only with oscillator off in sleep
      do_reset(1'b0);
      write_cfg(0, 1);
      do_kick();
      sleep = 1'b1;
      ls_osc_off = 1'b1;
      quiet(200, seen);
      check(seen == 0, "R8 flexible pause with oscillator off", seen, 0);
      ls_osc_off = 1'b0;
      measure(100, n);
      check(n >= 28 && n <= 44, "R8 sleep alone does not pause", n, 32);
      sleep = 1'b0;

      do_reset(1'b1);
      write_cfg(0, 0);
      do_kick();
      sleep = 1'b1;
      ls_osc_off = 1'b1;
      measure(400, n);
      check(n >= 28 && n <= 44, "R8 locked ignores oscillator-off", n, 32);
      sleep = 1'b0;
      ls_osc_off = 1'b0;

      // R9: one tick per low-speed rising edge (period 4 system cycles)
      do_reset(1'b0);
      write_cfg(2, 3);
      do_kick();
      measure(400, n);
      check(n >= 124 && n <= 136, "R9 synchronised tick rate", n, 128);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(8 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule